// File: doc/BRIEF.md
# Mixed-Sign Integer Multiplier

This block forms integer products for several operand-sign combinations on one shared 17x17 signed multiply array. Each operand is widened to 17 bits before the multiply. A signed operand copies its bit 15 into bit 16, and an unsigned operand gets a zero there. The one array therefore serves signed, unsigned and mixed-sign products alike.

A three-bit mode input picks the combination. The second operand can be a 16-bit word or a 5-bit unsigned literal. One mode multiplies the low bytes of both operands as unsigned values and returns a 16-bit product, zero-extended to the output width. The result is captured in an output register, so it appears one clock after the operands are presented. A new operation can start on every cycle.

Top module: `mixmul_top`

## Requirements
- R1: The product output is registered. Operands sampled at a rising edge appear on `product` after that edge. While `rst_n` is low, `product` is cleared to zero.
- R2: Mode code 0 multiplies `opa` and `opb` as signed 16-bit two's complement values and returns the full 32-bit two's complement product. For example, -32768 x -32768 gives 0x40000000.
- R3: Mode code 1 multiplies `opa` and `opb` as unsigned 16-bit values and returns the full 32-bit product. For example, 65535 x 65535 gives 0xFFFE0001.
- R4: Mode code 2 treats `opa` as unsigned and `opb` as signed, and returns the 32-bit two's complement product.
- R5: Mode code 3 multiplies signed `opa` by `lit`, where `lit` is read as unsigned 0..31. The result is a 32-bit two's complement product, and `opb` has no effect.
- R6: Mode code 4 multiplies unsigned `opa` by unsigned `lit` (0..31). The result never exceeds 2031585, and `opb` has no effect.
- R7: Mode code 5 multiplies `opa[7:0]` by `opb[7:0]` as unsigned bytes. The 16-bit product sits in `product[15:0]`, bits 31:16 are zero, and the upper operand bytes have no effect.
- R8: Mode codes 6 and 7 are unused and produce a product of zero.
- R9: Operations issued on consecutive cycles each produce their own correct product on consecutive cycles, with no influence from the previous operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Multiply mode code (0..5 used) |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand (word modes and byte mode) |
| lit | input | 5 | Unsigned literal second operand (literal modes) |
| product | output | 32 | Registered product |

## Verification
A wrong extension bit inside the block shows up on the port one clock after the operands are applied. A signed operand handled as unsigned, or an unsigned one as signed, puts an offset of 65536 times the other operand into `product` for any operand whose top bit is set, and the sign corners expose it straight away. A fault in the result selection shows up the same cycle: stray upper bits in byte mode, or a nonzero value for an unused code. A register that holds stale data fails the back-to-back run on the first changed operand.

// File: rtl/mixmul_pkg.sv
// Shared widths, mode codes and mode decode for the mixed-sign multiplier.
// Assumes 16-bit word operands and one 17-bit signed core.
package mixmul_pkg;
    localparam int OPW = 16;          // word operand width
    localparam int CW  = OPW + 1;     // core operand width
    localparam int PW  = 2 * OPW;     // product width
    localparam int LW  = 5;           // literal width
    localparam int BW  = 8;           // byte-mode operand width
    localparam int MW  = 3;           // mode code width

    typedef enum logic [MW-1:0] {
        MD_SS = 3'd0,
        MD_UU = 3'd1,
        MD_US = 3'd2,
        MD_SL = 3'd3,
        MD_UL = 3'd4,
        MD_B8 = 3'd5
    } mode_e;

    typedef struct packed {
        logic a_sgn;
        logic b_sgn;
        logic use_lit;
        logic byte_sel;
        logic legal;
    } ctl_t;

    // Turn a mode code into per-operand extension controls.
    function automatic ctl_t decode(input logic [MW-1:0] m);
        ctl_t c;
        c = '0;
        case (m)
            MD_SS: begin c.a_sgn = 1'b1; c.b_sgn = 1'b1; c.legal = 1'b1; end
            MD_UU: begin c.legal = 1'b1; end
            MD_US: begin c.b_sgn = 1'b1; c.legal = 1'b1; end
            MD_SL: begin c.a_sgn = 1'b1; c.use_lit = 1'b1; c.legal = 1'b1; end
            MD_UL: begin c.use_lit = 1'b1; c.legal = 1'b1; end
            MD_B8: begin c.byte_sel = 1'b1; c.legal = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/mixmul_ext.sv
// Widens one operand to the core width. In byte mode only the low byte is
// kept, zero-extended. Otherwise the top bit is copied upward when sgn is
// set, and zero is used when it is clear.
module mixmul_ext #(
    parameter int IW = 16,
    parameter int CW = 17,
    parameter int BW = 8
) (
    input  logic [IW-1:0] din,
    input  logic          sgn,
    input  logic          byte_sel,
    output logic [CW-1:0] dout
);
    // Choose the extension that matches the operand's interpretation.
    always_comb begin
        if (byte_sel) dout = {{(CW-BW){1'b0}}, din[BW-1:0]};
        else          dout = {{(CW-IW){sgn & din[IW-1]}}, din};
    end
endmodule

// File: rtl/mixmul_core.sv
// Signed CW x CW multiply array. Both inputs are always taken as two's
// complement, and the caller supplies correctly extended operands.
module mixmul_core #(
    parameter int CW = 17
) (
    input  logic signed [CW-1:0]   a,
    input  logic signed [CW-1:0]   b,
    output logic signed [2*CW-1:0] p
);
    // Full-width signed product.
    always_comb p = a * b;
endmodule

// File: rtl/mixmul_fmt.sv
// Trims the core's full product to the output width. Byte mode keeps
// 2*BW bits and zero-fills the rest. Unused modes give zero.
module mixmul_fmt #(
    parameter int CW = 17,
    parameter int PW = 32,
    parameter int BW = 8
) (
    input  logic [2*CW-1:0] full,
    input  logic            byte_sel,
    input  logic            legal,
    output logic [PW-1:0]   res
);
    // Select the result view for the active mode.
    always_comb begin
        if (!legal)        res = '0;
        else if (byte_sel) res = {{(PW-2*BW){1'b0}}, full[2*BW-1:0]};
        else               res = full[PW-1:0];
    end
endmodule

// File: rtl/mixmul_top.sv
// Mixed-sign integer multiplier: decodes the mode, extends both operands,
// multiplies on one signed core and registers the formatted product.
// Assumes a synchronous active-low reset and one result per clock.
module mixmul_top
    import mixmul_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] mode,
    input  logic [OPW-1:0] opa,
    input  logic [OPW-1:0] opb,
    input  logic [LW-1:0] lit,
    output logic [PW-1:0] product
);
    ctl_t            ctl;
    logic [OPW-1:0]  b_word;
    logic [CW-1:0]   a_ext;
    logic [CW-1:0]   b_ext;
    logic [2*CW-1:0] full;
    logic [PW-1:0]   res;

    // Mode decode.
    always_comb ctl = decode(mode);

    // Second operand: the word, or the zero-extended literal.
    always_comb b_word = ctl.use_lit ? {{(OPW-LW){1'b0}}, lit} : opb;

    mixmul_ext #(.IW(OPW), .CW(CW), .BW(BW)) i_ext_a (
        .din(opa), .sgn(ctl.a_sgn), .byte_sel(ctl.byte_sel), .dout(a_ext)
    );

    mixmul_ext #(.IW(OPW), .CW(CW), .BW(BW)) i_ext_b (
        .din(b_word), .sgn(ctl.b_sgn), .byte_sel(ctl.byte_sel), .dout(b_ext)
    );

    mixmul_core #(.CW(CW)) i_core (
        .a(a_ext), .b(b_ext), .p(full)
    );

    mixmul_fmt #(.CW(CW), .PW(PW), .BW(BW)) i_fmt (
        .full(full), .byte_sel(ctl.byte_sel), .legal(ctl.legal), .res(res)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) product <= '0;
        else        product <= res;
    end
endmodule

// File: rtl/mixmul_chk.sv
// Port-level properties of the multiplier, bound to every mixmul_top.
module mixmul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  mode,
    input logic [15:0] opa,
    input logic [15:0] opb,
    input logic [4:0]  lit,
    input logic [31:0] product
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> product == 32'd0);

    a_r2_sign_of_product: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && opa != 16'd0 && opb != 16'd0) |=>
        product[31] == ($past(opa[15]) ^ $past(opb[15])));

    a_r5_unit_literal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && lit == 5'd1) |=>
        product == {{16{$past(opa[15])}}, $past(opa)});

    a_r6_literal_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> product <= 32'd2031585);

    a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5) |=> product[31:16] == 16'd0);

    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > 3'd5) |=> product == 32'd0);

    a_r9_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (opa == 16'd0) |=> product == 32'd0);
endmodule

bind mixmul_top mixmul_chk i_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .opa(opa), .opb(opb),
    .lit(lit), .product(product)
);

// File: tb/test_mixmul_top.sv
module test_mixmul_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [4:0]  lit = '0;
    logic [31:0] product;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mixmul_top i_mixmul_top (
        .clk(clk), .rst_n(rst_n), .mode(mode), .opa(opa), .opb(opb),
        .lit(lit), .product(product)
    );

    // Reference built from the requirement text.
    function automatic logic [31:0] ref_prod(input logic [2:0] m,
            input logic [15:0] a, input logic [15:0] b, input logic [4:0] l);
        longint x, y, p;
        x = 0; y = 0;
        case (m)
            3'd0: begin x = longint'($signed(a)); y = longint'($signed(b)); end
            3'd1: begin x = longint'(a); y = longint'(b); end
            3'd2: begin x = longint'(a); y = longint'($signed(b)); end
            3'd3: begin x = longint'($signed(a)); y = longint'(l); end
            3'd4: begin x = longint'(a); y = longint'(l); end
            3'd5: begin x = longint'(a[7:0]); y = longint'(b[7:0]); end
            default: begin x = 0; y = 0; end
        endcase
        p = x * y;
        return p[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (product !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, product, exp);
        end
    endtask

    // Drive one operation and check it one edge later.
    task automatic run_op(input string req, input logic [2:0] m,
            input logic [15:0] a, input logic [15:0] b, input logic [4:0] l);
        @(negedge clk);
        mode = m; opa = a; opb = b; lit = l;
        @(posedge clk); #1;
        check(req, ref_prod(m, a, b, l));
    endtask

    task automatic t_reset();
        run_op("R1", 3'd1, 16'hFFFF, 16'hFFFF, 5'd0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", 32'd0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_signed();
        run_op("R2", 3'd0, 16'h8000, 16'h8000, 5'd0);
        check("R2", 32'h4000_0000);
        run_op("R2", 3'd0, 16'h8000, 16'h7FFF, 5'd0);
        run_op("R2", 3'd0, 16'hFFFF, 16'hFFFF, 5'd0);
        run_op("R2", 3'd0, 16'h1234, 16'hFEDC, 5'd0);
    endtask

    task automatic t_unsigned();
        run_op("R3", 3'd1, 16'hFFFF, 16'hFFFF, 5'd0);
        check("R3", 32'hFFFE_0001);
        run_op("R3", 3'd1, 16'h8000, 16'h0002, 5'd0);
        run_op("R3", 3'd1, 16'hABCD, 16'h1357, 5'd0);
    endtask

    task automatic t_mixed();
        run_op("R4", 3'd2, 16'hFFFF, 16'hFFFF, 5'd0);
        check("R4", 32'hFFFF_0001);
        run_op("R4", 3'd2, 16'h8000, 16'h8000, 5'd0);
        run_op("R4", 3'd2, 16'hC001, 16'h7FFF, 5'd0);
    endtask

    task automatic t_lit_signed();
        run_op("R5", 3'd3, 16'h8000, 16'hFFFF, 5'd31);
        check("R5", 32'hFFF0_8000);
        run_op("R5", 3'd3, 16'h7FFF, 16'h1234, 5'd17);
        run_op("R5", 3'd3, 16'hFFFE, 16'h0000, 5'd0);
    endtask

    task automatic t_lit_unsigned();
        run_op("R6", 3'd4, 16'hFFFF, 16'hAAAA, 5'd31);
        check("R6", 32'd2031585);
        run_op("R6", 3'd4, 16'h8001, 16'h5555, 5'd16);
    endtask

    task automatic t_byte();
        run_op("R7", 3'd5, 16'hABFF, 16'h12FF, 5'd0);
        check("R7", 32'h0000_FE01);
        run_op("R7", 3'd5, 16'hFF80, 16'h0003, 5'd9);
    endtask

    task automatic t_unused();
        run_op("R8", 3'd6, 16'h1234, 16'h5678, 5'd3);
        check("R8", 32'd0);
        run_op("R8", 3'd7, 16'hFFFF, 16'hFFFF, 5'd31);
    endtask

    task automatic t_stream();
        logic [15:0] s;
        s = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            run_op("R9", 3'(i % 6), s, ~{s[7:0], s[15:8]}, s[4:0]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        check("R1", 32'd0);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_signed();
        t_unsigned();
        t_mixed();
        t_lit_signed();
        t_lit_unsigned();
        t_byte();
        t_unused();
        t_stream();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R9 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule